// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two 32-bit integers over a series of clock cycles and leaves the full 64-bit product in two result registers. `hi` holds the upper word and `lo` the lower word, so a caller that only wants a truncated 32-bit result reads `lo`. The `signed_mode` input picks between two's-complement and unsigned interpretation of both operands. It is sampled, along with the operands, on the cycle a start is accepted.

Each iteration consumes one multiplier bit. The conditional add and the right shift of the product register happen in the same cycle, so an operation takes exactly 32 iterations. The `busy` output is high while it runs. `done` pulses for one cycle when the product is ready. The `wide` output reports whether the product needs more than 32 bits under the selected interpretation.

Top module: `seq_mul32`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `busy`, `done` and `wide` are 0 and `hi` and `lo` are all zeros. A reset in the middle of an operation abandons it.
- R2: With `signed_mode` = 0 at start, `{hi,lo}` equals the unsigned product of `mcand` and `mplier`.
- R3: With `signed_mode` = 1 at start, `{hi,lo}` equals the 64-bit two's-complement product. This holds for operands of 0, 1, -1, 0x80000000 and 0x7FFFFFFF.
- R4: A start accepted at clock edge E raises `busy` after E. `done` is high for exactly one cycle, after edge E+32, and at that point `busy` is low.
- R5: A `start` pulse seen while `busy` is high is ignored. This includes the cycle of the last iteration. The running operation finishes on time with an unchanged result.
- R6: In unsigned mode, `wide` is 1 exactly when `hi` is nonzero.
- R7: In signed mode, `wide` is 1 exactly when `hi` differs from 32 copies of `lo[31]`.
- R8: `mcand`, `mplier` and `signed_mode` are sampled only on the edge where a start is accepted. Changing them afterwards does not alter the result.
- R9: While idle and `start` is low, `hi` and `lo` keep the last product.
- R10: A `start` that is high in the same cycle as `done` is accepted, and it begins a new operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin an operation; accepted when not busy |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| mcand | input | 32 | Multiplicand |
| mplier | input | 32 | Multiplier |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the product is ready |
| hi | output | 32 | Upper word of the product |
| lo | output | 32 | Lower word of the product |
| wide | output | 1 | Product does not fit in 32 bits for the chosen mode |

## Verification
Two events can land on the same cycle: the completion of an operation and a new start request. The bench provokes both orderings around that boundary. In the first, it raises `start` with fresh operands during the final iteration, while `busy` is still high. It then holds `start` into the `done` cycle. The first product must appear unchanged, proving the early request was dropped. The request held into the `done` cycle must be taken, which is judged by `busy` rising again and a second correct signed product arriving 32 cycles later.

// File: rtl/seq_mul32.sv
module seq_mul32 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         signed_mode,
  input  logic [W-1:0] mcand,
  input  logic [W-1:0] mplier,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo,
  output logic         wide
);
  localparam int CW = $clog2(W);

  logic [CW-1:0] cnt;
  logic          sgn;
  logic [W-1:0]  a_q;
  logic [W:0]    sum;

  wire       last = (cnt == CW'(W - 1));
  wire [W:0] hi_x = {sgn & hi[W-1], hi};
  wire [W:0] a_x  = {sgn & a_q[W-1], a_q};

  always_comb begin
    if (!lo[0])
      sum = hi_x;
    else if (sgn && last)
      sum = hi_x - a_x;
    else
      sum = hi_x + a_x;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
      sgn  <= 1'b0;
      a_q  <= '0;
      hi   <= '0;
      lo   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          cnt  <= '0;
          sgn  <= signed_mode;
          a_q  <= mcand;
          hi   <= '0;
          lo   <= mplier;
        end
      end else begin
        {hi, lo} <= {sum, lo[W-1:1]};
        cnt      <= cnt + 1'b1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign wide = sgn ? (hi != {W{lo[W-1]}}) : (hi != '0);
endmodule

// File: rtl/seq_mul32_chk.sv
module seq_mul32_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] hi,
  input logic [W-1:0] lo
);
  localparam int RW = $clog2(W + 1) + 1;

  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n)
      run <= '0;
    else if (!busy && start)
      run <= '0;
    else if (busy)
      run <= run + 1'b1;
  end

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  done_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run == RW'(W) && !busy));

  // R5
  busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  // R10
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(hi) && $stable(lo)));
endmodule

bind seq_mul32 seq_mul32_chk #(.W(W)) chk_i (
  .clk  (clk),
  .rst_n(rst_n),
  .start(start),
  .busy (busy),
  .done (done),
  .hi   (hi),
  .lo   (lo)
);

// File: tb/seq_mul32_tb_top.sv
module seq_mul32_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;

  // {signed_mode, mcand, mplier}
  localparam logic [64:0] VEC [NV] = '{
    {1'b0, 32'h0000_0000, 32'h1234_5678},
    {1'b0, 32'h0000_0001, 32'hFFFF_FFFF},
    {1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {1'b0, 32'h8000_0000, 32'h0000_0002},
    {1'b0, 32'h7FFF_FFFF, 32'h7FFF_FFFF},
    {1'b0, 32'h0001_0000, 32'h0001_0000},
    {1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {1'b1, 32'h8000_0000, 32'h8000_0000},
    {1'b1, 32'h8000_0000, 32'h0000_0001},
    {1'b1, 32'h7FFF_FFFF, 32'h8000_0000},
    {1'b1, 32'hFFFF_FFFF, 32'h0000_0001},
    {1'b1, 32'h0001_0000, 32'h0000_8000},
    {1'b1, 32'h0000_0000, 32'h8000_0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mode = 1'b0;
  logic [31:0] mc = '0;
  logic [31:0] mp = '0;
  logic        busy, done, wide;
  logic [31:0] hi, lo;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  seq_mul32 #(.W(32)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .signed_mode(mode),
    .mcand      (mc),
    .mplier     (mp),
    .busy       (busy),
    .done       (done),
    .hi         (hi),
    .lo         (lo),
    .wide       (wide)
  );

  function automatic logic [63:0] ref_mul(input logic m, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] ea, eb;
    ea = m ? {{32{a[31]}}, a} : {32'b0, a};
    eb = m ? {{32{b[31]}}, b} : {32'b0, b};
    return ea * eb;
  endfunction

  function automatic logic ref_wide(input logic m, input logic [63:0] p);
    return m ? (p[63:32] != {32{p[31]}}) : (p[63:32] != 32'b0);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic m, input logic [31:0] a, input logic [31:0] b, input bit disturb);
    logic [63:0] p;
    int cyc;
    p = ref_mul(m, a, b);
    @(negedge clk);
    mode = m; mc = a; mp = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R4 busy after accepted start", 64'(busy), 64'd1);
    cyc = 0;
    while (done !== 1'b1 && cyc < 40) begin
      @(negedge clk);
      cyc++;
      if (disturb) begin
        mode  = ~mode;
        mc    = $urandom;
        mp    = $urandom;
        start = (cyc == 5);
      end
    end
    chk(cyc == 32, "R4 done latency", 64'(cyc), 64'd32);
    if (disturb)
      chk(cyc == 32, "R5 start while busy ignored", 64'(cyc), 64'd32);
    chk(busy === 1'b0, "R4 busy low at done", 64'(busy), 64'd0);
    if (m)
      chk({hi, lo} === p, "R3 signed product", {hi, lo}, p);
    else
      chk({hi, lo} === p, "R2 unsigned product", {hi, lo}, p);
    if (disturb)
      chk({hi, lo} === p, "R8 inputs ignored while busy", {hi, lo}, p);
    if (m)
      chk(wide === ref_wide(m, p), "R7 signed overflow flag", 64'(wide), 64'(ref_wide(m, p)));
    else
      chk(wide === ref_wide(m, p), "R6 unsigned overflow flag", 64'(wide), 64'(ref_wide(m, p)));
    @(negedge clk);
    chk(done === 1'b0, "R4 done lasts one cycle", 64'(done), 64'd0);
    chk({hi, lo} === p, "R9 result held while idle", {hi, lo}, p);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] p;
    int cyc;
    repeat (3) @(negedge clk);
    chk({busy, done, wide} === 3'b000, "R1 flags in reset", 64'({busy, done, wide}), 64'd0);
    chk({hi, lo} === 64'd0, "R1 result in reset", {hi, lo}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, wide} === 3'b000, "R1 flags after reset", 64'({busy, done, wide}), 64'd0);

    for (int i = 0; i < NV; i++)
      run_op(VEC[i][64], VEC[i][63:32], VEC[i][31:0], (i % 3) == 1);

    for (int i = 0; i < 20; i++)
      run_op(i[0], $urandom, $urandom, i[1]);

    // R5 / R10: request in last iteration dropped, request in done cycle taken
    @(negedge clk);
    mode = 1'b0; mc = 32'd3; mp = 32'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (31) @(negedge clk);
    mode = 1'b1; mc = 32'hFFFF_FFFE; mp = 32'd7; start = 1'b1;
    @(negedge clk);
    chk(done === 1'b1, "R5 done on time despite late start", 64'(done), 64'd1);
    chk({hi, lo} === 64'd15, "R5 first product kept", {hi, lo}, 64'd15);
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R10 start in done cycle accepted", 64'(busy), 64'd1);
    p = ref_mul(1'b1, 32'hFFFF_FFFE, 32'd7);
    cyc = 0;
    while (done !== 1'b1 && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == 32, "R10 second operation latency", 64'(cyc), 64'd32);
    chk({hi, lo} === p, "R10 second product", {hi, lo}, p);

    // R1: reset abandons a running operation
    @(negedge clk);
    mode = 1'b0; mc = 32'hFFFF_FFFF; mp = 32'hFFFF_FFFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk({busy, done, wide} === 3'b000, "R1 flags after mid-run reset", 64'({busy, done, wide}), 64'd0);
    chk({hi, lo} === 64'd0, "R1 result after mid-run reset", {hi, lo}, 64'd0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R1 no stale completion", 64'({busy, done}), 64'd0);

    run_op(1'b1, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule